// File: doc/BRIEF.md
# Suspendable Single-Channel DMA Mover

This block is one DMA channel that copies data from a source address to a destination address. Each unit is a byte or a word. Software loads the two addresses, a unit count and a control word through a small register port. The channel asks for the system bus with a request/grant handshake. Once it has the bus, it runs each unit as one read cycle followed by one write cycle on a simple memory master port. After every unit it steps both addresses on their own (forward, backward or held) and decrements the count. When the count reaches zero it closes the channel and raises an end flag.

The channel has two bus modes. In cycle-steal mode it returns the bus after every unit and asks for it again. In burst mode it keeps the bus until the count is used up. A transfer needs two enable bits: a per-channel enable and a master enable. The master enable is also the suspend bit. A rising edge on the non-maskable interrupt input clears it, but only in burst mode. The channel then completes the unit it has started, releases the bus and waits. It keeps its address and count state, so it carries on from where it stopped when software sets the master enable again. Clearing the channel enable pauses the channel in the same clean way, in either mode.

Top module: `dma_burst_chan`

## Requirements
- R1: Units are requested and moved only while control bit 0 (channel enable) and control bit 1 (master enable) are both 1 and the count register is non-zero. Otherwise `bus_req` stays low and no memory cycle is issued.
- R2: `reg_sel` selects the register: 0 is the source address, 1 is the destination address, 2 is the unit count and 3 is the control word. A write with `reg_wr` high loads the selected register. `reg_rdata` returns the selected register at any time.
- R3: Each unit is a read at the source address with `mem_rd` high, then in the next cycle a write at the destination address with `mem_wr` high. The write carries the data that was read. In byte mode only the low 8 bits are carried and the upper bits are zero. `mem_word` follows control bit 3 (1 = word).
- R4: When control bit 2 (burst) is 1, a rising edge on `nmi` clears the master enable. The unit in progress completes, then `bus_req` falls. Addresses and count hold their reached values. Writing the master enable to 1 resumes from those values.
- R5: When control bit 2 is 0, an `nmi` edge leaves the master enable unchanged and the transfer runs to completion.
- R6: `nmi` is sampled once per clock and acts only on its rising edge. A pulse held for many cycles clears the master enable once, and software can set it again while `nmi` is still high.
- R7: Control bits 5:4 set the source step and bits 7:6 set the destination step: 1 adds one unit, 2 subtracts one unit, and 0 or 3 hold the address. One unit is 1 in byte mode and DW/8 in word mode.
- R8: The count drops by one per completed unit. After the unit that takes it to zero, the channel enable clears, control bit 8 (end flag) and `irq_end` go to 1, and `bus_req` falls.
- R9: Writing the channel enable to 0 while the channel runs stops it after the unit in progress. Writing it to 1 again continues from the reached addresses and count.
- R10: In burst mode `bus_req` stays high without a gap from the first unit to the last. No memory cycle is issued before `bus_gnt` is seen.
- R11: In cycle-steal mode `bus_req` falls for at least one cycle after every unit. Each unit therefore begins with a new request.
- R12: Writing 0 to control bit 8 clears the end flag. Writing 1 to it leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Selected register contents |
| nmi | input | 1 | Non-maskable interrupt request |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_word | output | 1 | 1 for a word unit, 0 for a byte unit |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the read cycle |
| irq_end | output | 1 | Transfer-end flag |

## Verification
Complete transfers are run in cycle-steal and in burst mode, in byte and word size, with every step code. Byte and word runs differ in the data lanes, and the held, forward and backward steps each move the addresses differently. Counting bus request edges shows whether the bus was released between units. An NMI is applied mid-burst and held through the resume, and also mid cycle-steal. This separates edge detection from level detection and shows whether the mode gate works. Pausing by channel enable, starting with one enable low or a zero count, a delayed grant, and writes to the end flag check the gating and the resume-from-reached-state behaviour.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2,
      STEP_KEEP = 2'd3
   } step_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ASK   = 2'd1,
      SQ_READ  = 2'd2,
      SQ_WRITE = 2'd3
   } seq_e;

   typedef struct packed {
      logic  end_flag;   // bit 8
      step_e dst_step;   // bits 7:6
      step_e src_step;   // bits 5:4
      logic  word;       // bit 3
      logic  burst;      // bit 2
      logic  master_en;  // bit 1
      logic  chan_en;    // bit 0
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;
   localparam logic [1:0] SEL_CTL = 2'd3;

endpackage

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
   import dma_burst_pkg::*;
#(
   parameter int NMI_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  ctl_t wdata,
   input  logic nmi,
   input  logic done,
   output ctl_t ctl
);

   logic nmi_s;
   logic nmi_q;
   logic nmi_edge;
   ctl_t ctl_nx;

   generate
      if (NMI_SYNC == 0) begin : g_nmi_direct
         assign nmi_s = nmi;
      end else begin : g_nmi_sync
         logic [NMI_SYNC-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= nmi;
               for (int i = 1; i < NMI_SYNC; i++) sh[i] <= sh[i-1];
            end
         end
         assign nmi_s = sh[NMI_SYNC-1];
      end
   endgenerate

   assign nmi_edge = nmi_s & ~nmi_q;

   always_comb begin
      ctl_nx = ctl;
      if (wr) begin
         ctl_nx.chan_en   = wdata.chan_en;
         ctl_nx.master_en = wdata.master_en;
         ctl_nx.burst     = wdata.burst;
         ctl_nx.word      = wdata.word;
         ctl_nx.src_step  = wdata.src_step;
         ctl_nx.dst_step  = wdata.dst_step;
         if (!wdata.end_flag) ctl_nx.end_flag = 1'b0;
      end
      if (nmi_edge && ctl.burst) ctl_nx.master_en = 1'b0;
      if (done) begin
         ctl_nx.chan_en  = 1'b0;
         ctl_nx.end_flag = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl   <= '0;
         nmi_q <= 1'b0;
      end else begin
         ctl   <= ctl_nx;
         nmi_q <= nmi_s;
      end
   end

   // R4: an NMI edge in burst mode takes the master enable down
   a_r4_nmi_burst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_edge && ctl.burst) |=> !ctl.master_en);

   // R5: outside burst mode an NMI edge leaves the master enable alone
   a_r5_nmi_other_mode_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_edge && !ctl.burst && !wr) |=> $stable(ctl.master_en));

   // R8: completion closes the channel and raises the end flag
   a_r8_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!ctl.chan_en && ctl.end_flag));

endmodule

// File: rtl/dma_burst_addr.sv
module dma_burst_addr
   import dma_burst_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_src,
   input  logic          ld_dst,
   input  logic          ld_cnt,
   input  logic [AW-1:0] wdata,
   input  logic          step,
   input  logic          word,
   input  step_e         src_step,
   input  step_e         dst_step,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [CW-1:0] count,
   output logic          cnt_zero,
   output logic          cnt_one
);

   localparam logic [AW-1:0] WORD_BYTES = AW'(DW / 8);

   function automatic logic [AW-1:0] delta(input step_e s, input logic w);
      logic [AW-1:0] u;
      u = w ? WORD_BYTES : AW'(1);
      case (s)
         STEP_UP:   return u;
         STEP_DOWN: return AW'(0) - u;
         default:   return '0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src   <= '0;
         dst   <= '0;
         count <= '0;
      end else if (step) begin
         src   <= src + delta(src_step, word);
         dst   <= dst + delta(dst_step, word);
         count <= count - CW'(1);
      end else begin
         if (ld_src) src   <= wdata;
         if (ld_dst) dst   <= wdata;
         if (ld_cnt) count <= wdata[CW-1:0];
      end
   end

   assign cnt_zero = (count == '0);
   assign cnt_one  = (count == CW'(1));

   // R8: one decrement per completed unit
   a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (count == $past(count) - CW'(1)));

   // R7: a held source address does not move across a unit
   a_r7_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (src_step == STEP_HOLD || src_step == STEP_KEEP)) |=> $stable(src));

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
   import dma_burst_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_ok,
   input  logic          burst,
   input  logic          cnt_zero,
   input  logic          cnt_one,
   input  logic          bus_gnt,
   input  logic [DW-1:0] rdata,
   output logic          bus_req,
   output logic          rd,
   output logic          wr,
   output logic          step,
   output logic          done,
   output logic [DW-1:0] data_q
);

   seq_e state;
   seq_e state_nx;

   always_comb begin
      state_nx = state;
      step     = 1'b0;
      done     = 1'b0;
      case (state)
         SQ_IDLE:  if (run_ok && !cnt_zero) state_nx = SQ_ASK;
         SQ_ASK: begin
            if (!run_ok)      state_nx = SQ_IDLE;
            else if (bus_gnt) state_nx = SQ_READ;
         end
         SQ_READ:  state_nx = SQ_WRITE;
         SQ_WRITE: begin
            step = 1'b1;
            if (cnt_one) begin
               done     = 1'b1;
               state_nx = SQ_IDLE;
            end else if (burst && run_ok) begin
               state_nx = SQ_READ;
            end else begin
               state_nx = SQ_IDLE;
            end
         end
         default: state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         data_q <= '0;
      end else begin
         state <= state_nx;
         if (state == SQ_READ) data_q <= rdata;
      end
   end

   assign bus_req = (state != SQ_IDLE);
   assign rd      = (state == SQ_READ);
   assign wr      = (state == SQ_WRITE);

   // R1: a request withdrawn for lack of enables issues no read
   a_r1_gate_before_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_ASK && !run_ok) |=> !rd);

   // R3: every read is followed by its write
   a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> wr);

   // R10: burst keeps the bus and goes straight into the next read
   a_r10_burst_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && burst && run_ok && !cnt_one) |=> (bus_req && rd));

   // R11: cycle-steal releases the bus after each unit
   a_r11_steal_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !burst) |=> !bus_req);

endmodule

// File: rtl/dma_burst_chan.sv
module dma_burst_chan
   import dma_burst_pkg::*;
#(
   parameter int AW       = 16,
   parameter int CW       = 16,
   parameter int DW       = 16,
   parameter int NMI_SYNC = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_sel,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   input  logic          nmi,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          mem_word,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          irq_end
);

   generate
      if (AW < CTL_W || AW < CW) begin : g_bad_aw
         $error("dma_burst_chan: AW must hold the control word and the count");
      end
      if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
         $error("dma_burst_chan: DW must be a whole number of bytes, at least 16");
      end
      if (NMI_SYNC < 0 || NMI_SYNC > 4) begin : g_bad_sync
         $error("dma_burst_chan: NMI_SYNC must be 0 to 4");
      end
   endgenerate

   ctl_t          ctl;
   logic [AW-1:0] src;
   logic [AW-1:0] dst;
   logic [CW-1:0] count;
   logic          cnt_zero;
   logic          cnt_one;
   logic          step;
   logic          done;
   logic [DW-1:0] data_q;
   logic          run_ok;

   assign run_ok = ctl.chan_en & ctl.master_en;

   dma_burst_ctl #(.NMI_SYNC(NMI_SYNC)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr && reg_sel == SEL_CTL),
      .wdata (ctl_t'(reg_wdata[CTL_W-1:0])),
      .nmi   (nmi),
      .done  (done),
      .ctl   (ctl)
   );

   dma_burst_addr #(.AW(AW), .CW(CW), .DW(DW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_src   (reg_wr && reg_sel == SEL_SRC),
      .ld_dst   (reg_wr && reg_sel == SEL_DST),
      .ld_cnt   (reg_wr && reg_sel == SEL_CNT),
      .wdata    (reg_wdata),
      .step     (step),
      .word     (ctl.word),
      .src_step (ctl.src_step),
      .dst_step (ctl.dst_step),
      .src      (src),
      .dst      (dst),
      .count    (count),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one)
   );

   dma_burst_seq #(.DW(DW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_ok   (run_ok),
      .burst    (ctl.burst),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one),
      .bus_gnt  (bus_gnt),
      .rdata    (mem_rdata),
      .bus_req  (bus_req),
      .rd       (mem_rd),
      .wr       (mem_wr),
      .step     (step),
      .done     (done),
      .data_q   (data_q)
   );

   always_comb begin
      case (reg_sel)
         SEL_SRC: reg_rdata = src;
         SEL_DST: reg_rdata = dst;
         SEL_CNT: reg_rdata = AW'(count);
         default: reg_rdata = AW'(ctl);
      endcase
   end

   assign mem_addr  = mem_rd ? src : dst;
   assign mem_word  = ctl.word;
   assign mem_wdata = ctl.word ? data_q : DW'(data_q[7:0]);
   assign irq_end   = ctl.end_flag;

   // R10: no memory cycle while the bus is not granted
   a_r10_access_granted: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> bus_gnt);

endmodule

// File: tb/dma_burst_chan_test.sv
module dma_burst_chan_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        nmi = 1'b0;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic        mem_word;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        irq_end;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_burst_chan uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi(nmi),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_end(irq_end)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   // behavioural memory, 1 KiB, little-endian words
   logic [7:0] mem [0:1023];
   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13 + 5) & 255);
   endfunction

   always_comb begin
      if (mem_word)
         mem_rdata = {mem[(int'(mem_addr) + 1) & 1023], mem[int'(mem_addr) & 1023]};
      else
         mem_rdata = {8'h00, mem[int'(mem_addr) & 1023]};
   end

   always @(posedge clk) begin
      if (mem_wr) begin
         mem[int'(mem_addr) & 1023] <= mem_wdata[7:0];
         if (mem_word) mem[(int'(mem_addr) + 1) & 1023] <= mem_wdata[15:8];
      end
   end

   // bus arbiter with programmable grant latency
   int gnt_lat = 0;
   int gcnt = 0;
   always @(posedge clk) begin
      if (!bus_req) begin
         gcnt    <= 0;
         bus_gnt <= 1'b0;
      end else if (gcnt >= gnt_lat) begin
         bus_gnt <= 1'b1;
      end else begin
         gcnt <= gcnt + 1;
      end
   end

   // reference model state
   int e_sa, e_da, e_ss, e_ds, e_cnt;
   bit e_word;
   int idx = 0;
   int req_rises = 0;
   logic req_prev = 1'b0;

   function automatic int dlt(input int code, input bit w);
      int u;
      u = w ? 2 : 1;
      if (code == 1) return u;
      if (code == 2) return -u;
      return 0;
   endfunction
   function automatic int exp_src(input int i);
      return (e_sa + i * dlt(e_ss, e_word)) & 16'hFFFF;
   endfunction
   function automatic int exp_dst(input int i);
      return (e_da + i * dlt(e_ds, e_word)) & 16'hFFFF;
   endfunction
   function automatic int exp_data(input int i);
      int a;
      a = exp_src(i);
      if (e_word) return {pat(a + 1), pat(a)};
      return {8'h00, pat(a)};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (bus_req && !req_prev) req_rises++;
         req_prev = bus_req;
         if (mem_rd || mem_wr) begin
            chk(bus_gnt, "R10 access without grant", int'(bus_gnt), 1);
            chk(idx < e_cnt, "R8 unit beyond count", idx, e_cnt);
            chk(mem_word == e_word, "R3 unit size", int'(mem_word), int'(e_word));
         end
         if (mem_rd)
            chk(int'(mem_addr) == exp_src(idx), "R7 source address", int'(mem_addr), exp_src(idx));
         if (mem_wr) begin
            chk(int'(mem_addr) == exp_dst(idx), "R7 destination address", int'(mem_addr), exp_dst(idx));
            chk(int'(mem_wdata) == exp_data(idx), "R3 write data", int'(mem_wdata), exp_data(idx));
            idx++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [15:0] mk(input bit ch, input bit ms, input bit bu,
                                      input bit wd, input int ss, input int ds, input bit ef);
      return {7'b0, ef, 2'(ds), 2'(ss), wd, bu, ms, ch};
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic setup(input int sa, input int da, input int cnt, input bit wd,
                        input int ss, input int ds);
      e_sa = sa; e_da = da; e_cnt = cnt; e_word = wd; e_ss = ss; e_ds = ds;
      idx = 0; req_rises = 0;
      wr(2'd0, 16'(sa));
      wr(2'd1, 16'(da));
      wr(2'd2, 16'(cnt));
   endtask

   task automatic wait_done();
      int n;
      n = 0;
      while (!irq_end && n < 3000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_idx(input int k);
      int n;
      n = 0;
      while (idx < k && n < 3000) begin @(negedge clk); n++; end
   endtask

   task automatic end_checks(input string tag);
      logic [15:0] v;
      chk(idx == e_cnt, {tag, " units moved"}, idx, e_cnt);
      chk(irq_end == 1'b1, {"R8 end flag ", tag}, int'(irq_end), 1);
      chk(bus_req == 1'b0, {"R8 bus released ", tag}, int'(bus_req), 0);
      rd(2'd2, v);
      chk(v == 16'h0, {"R8 count zero ", tag}, int'(v), 0);
      rd(2'd3, v);
      chk(v[0] == 1'b0, {"R8 channel enable cleared ", tag}, int'(v[0]), 0);
      rd(2'd0, v);
      chk(int'(v) == exp_src(e_cnt), {"R7 final source ", tag}, int'(v), exp_src(e_cnt));
      rd(2'd1, v);
      chk(int'(v) == exp_dst(e_cnt), {"R7 final destination ", tag}, int'(v), exp_dst(e_cnt));
   endtask

   initial begin
      logic [15:0] v;
      int held;
      for (int i = 0; i < 1024; i++) mem[i] = pat(i);
      e_cnt = 0; e_word = 0; e_sa = 0; e_da = 0; e_ss = 0; e_ds = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R2)
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         chk(v == 16'h0, "R2 reset register value", int'(v), 0);
      end
      chk(bus_req == 1'b0 && irq_end == 1'b0, "R1 idle after reset", int'({bus_req, irq_end}), 0);

      // R2 readback
      setup(16'h0123, 16'h0345, 7, 0, 1, 1);
      rd(2'd0, v); chk(v == 16'h0123, "R2 source readback", int'(v), 16'h0123);
      rd(2'd1, v); chk(v == 16'h0345, "R2 destination readback", int'(v), 16'h0345);
      rd(2'd2, v); chk(v == 16'd7, "R2 count readback", int'(v), 7);

      // R1: master enable low, no start
      wr(2'd3, mk(1, 0, 1, 0, 1, 1, 0));
      repeat (20) @(negedge clk);
      chk(req_rises == 0 && idx == 0, "R1 no start without master enable", req_rises, 0);
      wr(2'd3, mk(1, 1, 1, 0, 1, 1, 0));
      wait_done();
      end_checks("R1 late start");

      // R1: zero count, no start
      setup(16'h0010, 16'h0200, 0, 0, 1, 1);
      wr(2'd3, mk(1, 1, 1, 0, 1, 1, 0));
      repeat (20) @(negedge clk);
      chk(req_rises == 0, "R1 no start with zero count", req_rises, 0);

      // R11: byte cycle-steal, forward steps, grant latency 3
      gnt_lat = 3;
      setup(16'h0020, 16'h0220, 4, 0, 1, 1);
      wr(2'd3, mk(1, 1, 0, 0, 1, 1, 0));
      wait_done();
      end_checks("R11 byte steal");
      chk(req_rises == 4, "R11 one request per unit", req_rises, 4);
      gnt_lat = 0;

      // R10: word burst, source backward, destination forward
      setup(16'h0080, 16'h0240, 5, 1, 2, 1);
      wr(2'd3, mk(1, 1, 1, 1, 2, 1, 0));
      wait_done();
      end_checks("R10 word burst");
      chk(req_rises == 1, "R10 single request in burst", req_rises, 1);

      // R7: held source (code 3), destination backward, byte burst
      setup(16'h0055, 16'h02F0, 3, 0, 3, 2);
      wr(2'd3, mk(1, 1, 1, 0, 3, 2, 0));
      wait_done();
      end_checks("R7 hold and down");

      // R12: end flag write semantics
      wr(2'd3, mk(0, 0, 0, 0, 0, 0, 1));
      chk(irq_end == 1'b1, "R12 writing one keeps flag", int'(irq_end), 1);
      wr(2'd3, mk(0, 0, 0, 0, 0, 0, 0));
      chk(irq_end == 1'b0, "R12 writing zero clears flag", int'(irq_end), 0);

      // R4, R6: NMI during word burst, held through resume
      setup(16'h01F0, 16'h0280, 8, 1, 2, 1);
      wr(2'd3, mk(1, 1, 1, 1, 2, 1, 0));
      wait_idx(3);
      nmi = 1'b1;
      repeat (10) @(negedge clk);
      held = idx;
      chk(held < 8, "R4 burst suspended", held, 3);
      rd(2'd3, v);
      chk(v[1] == 1'b0, "R4 master enable cleared", int'(v[1]), 0);
      chk(v[0] == 1'b1, "R4 channel enable kept", int'(v[0]), 1);
      chk(bus_req == 1'b0, "R4 bus released", int'(bus_req), 0);
      rd(2'd2, v);
      chk(int'(v) == 8 - held, "R4 count held", int'(v), 8 - held);
      rd(2'd0, v);
      chk(int'(v) == exp_src(held), "R4 source held", int'(v), exp_src(held));
      repeat (10) @(negedge clk);
      chk(idx == held, "R4 no units while suspended", idx, held);
      wr(2'd3, mk(1, 1, 1, 1, 2, 1, 0));
      wait_done();
      end_checks("R4 resume");
      rd(2'd3, v);
      chk(v[1] == 1'b1, "R6 held NMI cleared master once", int'(v[1]), 1);
      chk(req_rises == 2, "R4 two bus tenures", req_rises, 2);
      nmi = 1'b0;
      repeat (2) @(negedge clk);

      // R5: NMI during cycle-steal has no effect
      setup(16'h0100, 16'h0300, 6, 0, 1, 1);
      wr(2'd3, mk(1, 1, 0, 0, 1, 1, 0));
      wait_idx(2);
      nmi = 1'b1;
      repeat (3) @(negedge clk);
      nmi = 1'b0;
      rd(2'd3, v);
      chk(v[1] == 1'b1, "R5 master enable kept in steal", int'(v[1]), 1);
      wait_done();
      end_checks("R5 steal with NMI");

      // R9: channel enable cleared mid burst, then resumed
      setup(16'h0140, 16'h0380, 10, 0, 1, 2);
      wr(2'd3, mk(1, 1, 1, 0, 1, 2, 0));
      wait_idx(4);
      wr(2'd3, mk(0, 1, 1, 0, 1, 2, 0));
      repeat (5) @(negedge clk);
      held = idx;
      repeat (10) @(negedge clk);
      chk(idx == held && held < 10, "R9 paused by channel enable", idx, held);
      chk(bus_req == 1'b0, "R9 bus released on pause", int'(bus_req), 0);
      rd(2'd2, v);
      chk(int'(v) == 10 - held, "R9 count held", int'(v), 10 - held);
      wr(2'd3, mk(1, 1, 1, 0, 1, 2, 0));
      wait_done();
      end_checks("R9 resume");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule